// File: doc/BRIEF.md
# Gated Horizontal Sync Pulse Counter

This block counts rising edges of a horizontal sync signal inside a gate window and keeps the total of the last complete window in a result register. A display controller uses the result to judge the horizontal line rate. The gate comes from one of three sources. The first is the span from one vertical sync rising edge to the next. The other two are fixed internal windows built from a time-base tick, 2048 ticks (16.384 ms at 8 µs per tick) or 4096 ticks (32.768 ms).

When a window closes, the running total is copied into the result, the running counter restarts, and the next window begins at once. If the running counter would pass its largest value, it stays at that value and raises a sticky overflow flag. Only a one-cycle clear pulse lowers the flag, and the clear never touches the running count. A write to the mode register that changes the mode discards the current window, and the result keeps its old value.

Top module: `hsync_gate_counter`

## Requirements
- R1: Reset clears the result to 0, lowers the overflow flag and sets the mode register to {use_vsync=1, long=1}. The block therefore starts in vertical-sync gating with no mode write.
- R2: With mode_vsync=1, the result equals the number of hsync_i rising edges between two consecutive vsync_i rising edges. It is updated no later than 4 clocks after the closing vsync_i edge.
- R3: With mode_vsync=0, a window lasts SHORT_TICKS ticks when mode_long=0 and LONG_TICKS ticks when mode_long=1. One tick is TICK_DIV clocks. vsync_i has no effect on the result in this mode.
- R4: When an edge arrives while the running count is 2^CNT_W-1, the count holds that value and ovf_o goes to 1. A full window then reports 2^CNT_W-1.
- R5: ovf_o stays at 1 until ovf_clr_i is 1 for a cycle. If a new overflow occurs in the same cycle, the set takes priority.
- R6: ovf_clr_i does not change the running count. Edges before and after the clear add up in the result.
- R7: A mode_we write whose value differs from the mode register zeroes the running count and the window timer. No result is latched for the abandoned window.
- R8: An hsync_i edge that reaches the counter in the same cycle as the window-end event is counted in the new window.
- R9: The result changes only at a window end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Horizontal sync, resynchronized inside the block |
| vsync_i | input | 1 | Vertical sync, resynchronized inside the block |
| mode_we | input | 1 | Mode register write strobe |
| mode_vsync_i | input | 1 | Write data: 1 selects vertical-sync gating |
| mode_long_i | input | 1 | Write data: 1 selects the long internal window |
| ovf_clr_i | input | 1 | Write-1 pulse that clears the overflow flag |
| hcount_o | output | CNT_W | Count of the last complete window |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest state to reach is the saturation corner. The running count must be driven to its full 14-bit value and then receive one more edge inside a single window. The stimulus gets there with an uninterrupted train of 2^14 pulses between two vertical syncs. After that it checks that the flag survives the following window end and that a clear leaves a later window's count intact. The internal-window modes are checked with pulse trains whose period divides the window length. The expected total is then the same for any phase, even while vertical sync pulses arrive as noise.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

    typedef enum logic [1:0] {
        GATE_VSYNC = 2'd0,
        GATE_SHORT = 2'd1,
        GATE_LONG  = 2'd2
    } gate_e;

    typedef struct packed {
        logic use_vsync;
        logic long_win;
    } mode_t;

    localparam mode_t MODE_RESET = '{use_vsync: 1'b1, long_win: 1'b1};

    function automatic gate_e gate_of(input mode_t m);
        if (m.use_vsync)     return GATE_VSYNC;
        else if (m.long_win) return GATE_LONG;
        else                 return GATE_SHORT;
    endfunction

endpackage

// File: rtl/hsc_edge_sync.sv
module hsc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic rise_o
);
    logic [STAGES-1:0] sh;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], d_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= sh[STAGES-1];
    end

    assign rise_o = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/hsc_window_timer.sv
module hsc_window_timer #(
    parameter int TICK_DIV    = 400,
    parameter int SHORT_TICKS = 2048,
    parameter int LONG_TICKS  = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic run_i,
    input  logic long_i,
    output logic end_o
);
    localparam int PW = $clog2(TICK_DIV + 1);
    localparam int TW = $clog2(LONG_TICKS + 1);
    localparam logic [PW-1:0] PRE_LAST   = PW'(TICK_DIV - 1);
    localparam logic [TW-1:0] SHORT_LAST = TW'(SHORT_TICKS - 1);
    localparam logic [TW-1:0] LONG_LAST  = TW'(LONG_TICKS - 1);

    logic [PW-1:0] pre;
    logic [TW-1:0] ticks;
    logic          tick;
    logic [TW-1:0] last;

    assign tick  = run_i && (pre == PRE_LAST);
    assign last  = long_i ? LONG_LAST : SHORT_LAST;
    assign end_o = tick && (ticks == last);

    always_ff @(posedge clk) begin
        if (rst || restart_i || !run_i) begin
            pre   <= '0;
            ticks <= '0;
        end else begin
            pre <= tick ? '0 : pre + 1'b1;
            if (end_o)     ticks <= '0;
            else if (tick) ticks <= ticks + 1'b1;
        end
    end
endmodule

// File: rtl/hsc_accum.sv
module hsc_accum #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic             win_end_i,
    input  logic             edge_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] result_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic ovf_set;

    assign ovf_set = edge_i && !restart_i && !win_end_i && (cnt_o == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o    <= '0;
            result_o <= '0;
        end else if (restart_i) begin
            cnt_o <= '0;
        end else if (win_end_i) begin
            result_o <= cnt_o;
            cnt_o    <= CNT_W'(edge_i);
        end else if (edge_i && cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ovf_o <= 1'b0;
        else if (ovf_set) ovf_o <= 1'b1;
        else if (clr_i)   ovf_o <= 1'b0;
    end
endmodule

// File: rtl/hsync_gate_counter.sv
module hsync_gate_counter
    import hsc_pkg::*;
#(
    parameter int CNT_W       = 14,
    parameter int SYNC_STAGES = 2,
    parameter int TICK_DIV    = 400,
    parameter int SHORT_TICKS = 2048,
    parameter int LONG_TICKS  = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_i,
    input  logic             vsync_i,
    input  logic             mode_we,
    input  logic             mode_vsync_i,
    input  logic             mode_long_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] hcount_o,
    output logic             ovf_o
);
    mode_t            mode_q;
    mode_t            mode_new;
    gate_e            gate;
    logic             restart;
    logic             h_rise;
    logic             v_rise;
    logic             t_end;
    logic             win_end;
    logic [CNT_W-1:0] run_cnt;

    assign mode_new = '{use_vsync: mode_vsync_i, long_win: mode_long_i};
    assign restart  = mode_we && (mode_new != mode_q);
    assign gate     = gate_of(mode_q);

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= MODE_RESET;
        else if (mode_we) mode_q <= mode_new;
    end

    hsc_edge_sync #(.STAGES(SYNC_STAGES)) u_hsync (
        .clk(clk), .rst(rst), .d_i(hsync_i), .rise_o(h_rise)
    );

    hsc_edge_sync #(.STAGES(SYNC_STAGES)) u_vsync (
        .clk(clk), .rst(rst), .d_i(vsync_i), .rise_o(v_rise)
    );

    hsc_window_timer #(
        .TICK_DIV(TICK_DIV), .SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)
    ) u_timer (
        .clk(clk), .rst(rst), .restart_i(restart),
        .run_i(gate != GATE_VSYNC), .long_i(gate == GATE_LONG),
        .end_o(t_end)
    );

    assign win_end = (gate == GATE_VSYNC) ? v_rise : t_end;

    hsc_accum #(.CNT_W(CNT_W)) u_accum (
        .clk(clk), .rst(rst), .restart_i(restart), .win_end_i(win_end),
        .edge_i(h_rise), .clr_i(ovf_clr_i), .cnt_o(run_cnt),
        .result_o(hcount_o), .ovf_o(ovf_o)
    );
endmodule

// File: rtl/hsc_checker.sv
module hsc_checker #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             h_rise,
    input logic             win_end,
    input logic             restart,
    input logic             ovf_clr_i,
    input logic             ovf_o,
    input logic [CNT_W-1:0] hcount_o,
    input logic [CNT_W-1:0] run_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (hcount_o == '0 && !ovf_o)); // R1
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst) !win_end |=> $stable(hcount_o)); // R9
    AST_NO_PARTIAL_LATCH: assert property (@(posedge clk) disable iff (rst) restart |=> (run_cnt == '0 && $stable(hcount_o))); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) (ovf_o && !ovf_clr_i) |=> ovf_o); // R5
    AST_CLEAR_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst) (ovf_clr_i && !restart && !win_end && !h_rise) |=> $stable(run_cnt)); // R6
    AST_SATURATE: assert property (@(posedge clk) disable iff (rst) (run_cnt == CNT_MAX && h_rise && !win_end && !restart) |=> (run_cnt == CNT_MAX && ovf_o)); // R4
    AST_EDGE_IN_NEW_WINDOW: assert property (@(posedge clk) disable iff (rst) (win_end && h_rise && !restart) |=> (run_cnt == CNT_W'(1))); // R8
endmodule

bind hsync_gate_counter hsc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .h_rise(h_rise), .win_end(win_end), .restart(restart),
    .ovf_clr_i(ovf_clr_i), .ovf_o(ovf_o), .hcount_o(hcount_o), .run_cnt(run_cnt)
);

// File: tb/hsync_gate_counter_test.sv
module hsync_gate_counter_test;
    localparam int CNT_W    = 14;
    localparam int TDIV     = 2;
    localparam int SHORT_T  = 16;
    localparam int LONG_T   = 32;
    localparam int SHORT_CY = TDIV * SHORT_T;
    localparam int LONG_CY  = TDIV * LONG_T;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync_i = 1'b0, vsync_i = 1'b0;
    logic mode_we = 1'b0, mode_vsync_i = 1'b1, mode_long_i = 1'b1;
    logic ovf_clr_i = 1'b0;
    logic [CNT_W-1:0] hcount_o;
    logic ovf_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    hsync_gate_counter #(
        .CNT_W(CNT_W), .SYNC_STAGES(2), .TICK_DIV(TDIV),
        .SHORT_TICKS(SHORT_T), .LONG_TICKS(LONG_T)
    ) uut (
        .clk(clk), .rst(rst), .hsync_i(hsync_i), .vsync_i(vsync_i),
        .mode_we(mode_we), .mode_vsync_i(mode_vsync_i), .mode_long_i(mode_long_i),
        .ovf_clr_i(ovf_clr_i), .hcount_o(hcount_o), .ovf_o(ovf_o)
    );

    function automatic int expected_interval(input int window_cycles, input int period);
        return window_cycles / period;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_h(input int n);
        for (int i = 0; i < n; i++) begin
            hsync_i = 1'b1; @(negedge clk);
            hsync_i = 1'b0; @(negedge clk);
        end
    endtask

    task automatic pulse_v();
        vsync_i = 1'b1; @(negedge clk);
        vsync_i = 1'b0; @(negedge clk);
        idle(4);
    endtask

    task automatic write_mode(input logic use_v, input logic lng);
        mode_vsync_i = use_v; mode_long_i = lng; mode_we = 1'b1;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic clear_ovf();
        ovf_clr_i = 1'b1; @(negedge clk);
        ovf_clr_i = 1'b0; @(negedge clk);
    endtask

    task automatic train(input int period, input int cycles, input bit vnoise);
        for (int i = 0; i < cycles; i++) begin
            hsync_i = ((i % period) == 0);
            vsync_i = vnoise && ((i % 13) == 5);
            @(negedge clk);
        end
        hsync_i = 1'b0;
        vsync_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(64'd200000 * 64'd20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1 result after reset", hcount_o, 0);
        check("R1 overflow after reset", ovf_o, 0);

        // R1 / R2: no mode write, vertical-sync gating is active from reset
        pulse_v();
        check("R2 first window since reset", hcount_o, 0);
        pulse_h(7);
        check("R9 result held mid window", hcount_o, 0);
        pulse_v();
        check("R1 R2 default mode counts 7", hcount_o, 7);

        // R2 random windows
        for (int k = 0; k < 6; k++) begin
            int n;
            n = $urandom_range(0, 40);
            pulse_h(n);
            idle($urandom_range(0, 5));
            pulse_v();
            check("R2 random window", hcount_o, n);
        end

        // R8 edge coinciding with the window end goes to the new window
        pulse_h(3);
        hsync_i = 1'b1; vsync_i = 1'b1; @(negedge clk);
        hsync_i = 1'b0; vsync_i = 1'b0; @(negedge clk);
        idle(4);
        check("R8 closing window excludes coincident edge", hcount_o, 3);
        pulse_h(2);
        pulse_v();
        check("R8 new window includes coincident edge", hcount_o, 3);

        // R7 mode change discards the running count
        pulse_h(5);
        write_mode(1'b0, 1'b0);
        write_mode(1'b1, 1'b1);
        check("R7 no latch on mode change", hcount_o, 3);
        pulse_h(2);
        pulse_v();
        check("R7 count restarted", hcount_o, 2);

        // R7 switch to interval mode keeps the old result until a window ends
        write_mode(1'b0, 1'b0);
        idle(10);
        check("R7 result kept after switch", hcount_o, 2);
        idle(SHORT_CY + 4);
        check("R3 idle short window", hcount_o, 0);

        // R3 interval windows with random periods and vsync noise
        for (int k = 0; k < 6; k++) begin
            int p;
            bit lng;
            p   = 2 << $urandom_range(0, 3);
            lng = $urandom_range(0, 1);
            write_mode(1'b0, lng);
            train(p, (lng ? LONG_CY : SHORT_CY) * 3 + 8, 1'b1);
            check(lng ? "R3 long window count" : "R3 short window count",
                  hcount_o, expected_interval(lng ? LONG_CY : SHORT_CY, p));
        end

        // R4 saturation and overflow
        write_mode(1'b1, 1'b1);
        pulse_v();
        pulse_h(1 << CNT_W);
        idle(4);
        check("R4 overflow flag set", ovf_o, 1);
        pulse_v();
        check("R4 saturated result", hcount_o, (1 << CNT_W) - 1);
        check("R5 flag sticky across window end", ovf_o, 1);
        idle(20);
        check("R5 flag still set", ovf_o, 1);
        clear_ovf();
        check("R5 flag cleared", ovf_o, 0);

        // R6 clear leaves the running count intact
        pulse_h(5);
        clear_ovf();
        pulse_h(4);
        pulse_v();
        check("R6 count kept across clear", hcount_o, 9);
        check("R6 flag low", ovf_o, 0);

        finish_run();
    end
endmodule